// File: doc/BRIEF.md
# Two-Point Step Quotient Calibrator

This block works out how many ring-oscillator quotient units correspond to one regulator voltage step. It is a small sequencer between a voltage-request port and a measurement engine. When started for an operating mode it computes a starting level from the mode's maximum voltage, a target offset and the regulator step size, and asks the regulator for that level. It then enables the measurement loop under software control and waits, with a bounded poll, first for the engine's done flag and then for its busy flag to drop. At that point it captures the slow quotient from the engine's result word. The loop is switched off, a level four regulator steps lower is requested, and a second measurement follows. The slope (first quotient minus second, divided by four) goes into a per-mode cache, and its low byte is written to the step register.

Each mode's cache entry resets to an all-ones marker that means "not calibrated". Any other cached value makes a later start skip both measurements and write the stored value straight to the step register. If a poll runs out of time, the sequencer stops, raises a sticky error flag, asks for the regulator to be disabled, and leaves both the step register and the cache untouched.

Top module: `stepq_cal`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle: busy, error, regulator-request, regulator-disable, loop-enable and step-write outputs are low, and every mode's cache entry holds the all-ones "uncalibrated" marker.
- R2: On an accepted start for an uncalibrated mode, the first regulator request carries level = maximum voltage − target offset × step size. The request stays valid, with a stable level, until acknowledged.
- R3: The second regulator request carries a level exactly four step sizes below the first.
- R4: The loop-enable output is high only while a measurement is being polled. It is low while any regulator request is pending, so the loop is off between the two measurements.
- R5: Each measurement waits for the done flag and then for the busy flag to be low. The quotient is taken from result-word bits [QLSB+QUOT_W-1:QLSB] (QLSB = 12) when busy is seen low. Other bits of the word have no effect.
- R6: The slope is (first − second) arithmetically shifted right by 2, forced to zero when the second quotient is larger. Its low 8 bits are written with a one-cycle step-write pulse. A stored slope can never equal the all-ones marker.
- R7: A start for a mode whose cache entry is not all ones makes no regulator request and no measurement, and pulses step-write with the cached low byte in the cycle after the start. Cache entries are independent per mode.
- R8: If a condition is not met on any of POLL_MAX samples spaced POLL_TICKS cycles apart, the block raises the error flag, pulses regulator-disable for one cycle and returns to idle. It does not write the step register, and the mode stays uncalibrated.
- R9: A condition that becomes true at the last allowed sample counts as success.
- R10: A start while busy is ignored.
- R11: The error flag stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start a calibration for mode_i (accepted when idle) |
| mode_i | input | MODE_W | Operating mode selecting the cache entry |
| vmax_i | input | VOLT_W | Mode maximum voltage, in regulator units |
| tgt_off_i | input | OFF_W | Target offset, in regulator steps |
| step_size_i | input | VOLT_W | Regulator step size, in regulator units |
| vreq_valid_o | output | 1 | Voltage request valid |
| vreq_level_o | output | VOLT_W | Requested voltage level |
| vreq_ack_i | input | 1 | Regulator has applied the requested level |
| reg_off_o | output | 1 | One-cycle request to disable the regulator after a timeout |
| meas_en_o | output | 1 | Measurement loop enable |
| sw_mode_o | output | 1 | Loop under software control during the calibration run |
| done_flag_i | input | 1 | Measurement done flag from the engine |
| busy_flag_i | input | 1 | Engine busy flag from its result word |
| meas_word_i | input | DBG_W | Engine result word carrying the slow quotient |
| step_we_o | output | 1 | Step register write strobe |
| step_wdata_o | output | SR_W | Step register write data |
| busy_o | output | 1 | Sequencer not idle |
| err_o | output | 1 | Sticky poll-timeout error |

## Verification
Most internal faults become visible at the ports within one calibration run. A wrong level arithmetic or a missing phase change shows up as the wrong value on the two regulator requests. A bad field slice, subtraction, clamp or shift gives a wrong step-write byte in the cycle after the second busy-clear sample. A poll counter that is off by one either fails the request whose condition arrives at the last allowed sample, or lets a stuck flag pass without an error. A cache that loses its marker or its data is caught by the next start for that mode: it either makes regulator requests when it should not, or writes a different byte one cycle later.

// File: rtl/stepq_pkg.sv
package stepq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_VREQ  = 3'd1,
    ST_WDONE = 3'd2,
    ST_WBUSY = 3'd3,
    ST_GAP   = 3'd4,
    ST_PROG  = 3'd5,
    ST_ERR   = 3'd6
  } stepq_state_e;

endpackage

// File: rtl/stepq_math.sv
module stepq_math #(
  parameter int VOLT_W = 16,
  parameter int OFF_W  = 4,
  parameter int QUOT_W = 12
) (
  input  logic [VOLT_W-1:0] vmax_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [VOLT_W-1:0] step_i,
  input  logic [VOLT_W-1:0] lvl_cur_i,
  input  logic [VOLT_W-1:0] step_cur_i,
  input  logic [QUOT_W-1:0] q_hi_i,
  input  logic [QUOT_W-1:0] q_lo_i,
  output logic [VOLT_W-1:0] lvl_first_o,
  output logic [VOLT_W-1:0] lvl_next_o,
  output logic [QUOT_W-1:0] slope_o
);

  localparam int DW = QUOT_W + 1;

  logic [VOLT_W-1:0]   drop;
  logic signed [DW-1:0] diff;
  logic signed [DW-1:0] shr;

  // starting level: maximum less the offset in whole steps
  always_comb begin
    drop        = VOLT_W'(off_i) * step_i;
    lvl_first_o = vmax_i - drop;
  end

  // second level: four steps below the current one
  always_comb begin
    lvl_next_o = lvl_cur_i - (step_cur_i << 2);
  end

  // slope: signed difference divided by four, negative results forced to zero
  always_comb begin
    diff    = $signed({1'b0, q_hi_i}) - $signed({1'b0, q_lo_i});
    shr     = diff >>> 2;
    slope_o = shr[DW-1] ? '0 : shr[QUOT_W-1:0];
  end

endmodule

// File: rtl/stepq_poll.sv
module stepq_poll #(
  parameter int TICKS = 500,
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic cond_i,
  output logic hit_o,
  output logic expire_o
);

  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [TW-1:0] tick_q, tick_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sample;
  logic          tick_en;

  assign sample   = (tick_q == '0);
  assign hit_o    = active_i & sample & cond_i;
  assign expire_o = active_i & sample & ~cond_i & (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    tick_d  = tick_q;
    cnt_d   = cnt_q;
    tick_en = 1'b1;
    if (!active_i || hit_o || expire_o) begin
      tick_d = '0;
      cnt_d  = '0;
      tick_en = (tick_q != '0) || (cnt_q != '0);
    end else begin
      if (sample) cnt_d = cnt_q + CW'(1);
      tick_d = (tick_q == TW'(TICKS - 1)) ? '0 : tick_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      cnt_q  <= '0;
    end else if (tick_en) begin
      tick_q <= tick_d;
      cnt_q  <= cnt_d;
    end
  end

  // R8
  sample_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT - 1));

  // R8
  expire_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == '0));

endmodule

// File: rtl/stepq_cache.sv
module stepq_cache #(
  parameter int IW    = 2,
  parameter int W     = 12,
  parameter int OUT_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [OUT_W-1:0] prog_o,
  output logic          valid_o
);

  localparam int NUM = 1 << IW;

  logic [NUM-1:0][W-1:0] ent_q;
  logic [NUM-1:0]        sel;
  logic [W-1:0]          rd;

  for (genvar g = 0; g < NUM; g++) begin : g_sel
    assign sel[g] = we_i && (widx_i == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) ent_q[i] <= '1;
    end else begin
      for (int i = 0; i < NUM; i++) begin
        if (sel[i]) ent_q[i] <= wdata_i;
      end
    end
  end

  assign rd      = ent_q[ridx_i];
  assign valid_o = (rd != '1);
  assign prog_o  = rd[OUT_W-1:0];

  // R6
  marker_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (wdata_i != '1));

  // R7
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (ridx_i == widx_i)) |=> valid_o);

endmodule

// File: rtl/stepq_cal.sv
module stepq_cal
  import stepq_pkg::*;
#(
  parameter int VOLT_W     = 16,
  parameter int OFF_W      = 4,
  parameter int QUOT_W     = 12,
  parameter int QLSB       = 12,
  parameter int DBG_W      = 32,
  parameter int SR_W       = 8,
  parameter int MODE_W     = 2,
  parameter int POLL_TICKS = 500,
  parameter int POLL_MAX   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [VOLT_W-1:0] vmax_i,
  input  logic [OFF_W-1:0]  tgt_off_i,
  input  logic [VOLT_W-1:0] step_size_i,
  output logic              vreq_valid_o,
  output logic [VOLT_W-1:0] vreq_level_o,
  input  logic              vreq_ack_i,
  output logic              reg_off_o,
  output logic              meas_en_o,
  output logic              sw_mode_o,
  input  logic              done_flag_i,
  input  logic              busy_flag_i,
  input  logic [DBG_W-1:0]  meas_word_i,
  output logic              step_we_o,
  output logic [SR_W-1:0]   step_wdata_o,
  output logic              busy_o,
  output logic              err_o
);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  stepq_state_e      state_q, state_d;
  logic              phase_q, phase_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [VOLT_W-1:0] step_q, step_d;
  logic [VOLT_W-1:0] level_q, level_d;
  logic [QUOT_W-1:0] q1_q, q1_d;
  logic              err_q, err_d;

  logic              cfg_en, q1_en, gap_en, err_en;
  logic              cache_we, cache_valid;
  logic [MODE_W-1:0] rd_idx;
  logic [QUOT_W-1:0] quot_now, slope;
  logic [VOLT_W-1:0] lvl_first, lvl_next;
  logic              poll_active, poll_cond, poll_hit, poll_expire;

  // slow quotient field of the engine result word
  assign quot_now = QUOT_W'(meas_word_i >> QLSB);

  stepq_math #(
    .VOLT_W (VOLT_W),
    .OFF_W  (OFF_W),
    .QUOT_W (QUOT_W)
  ) u_math (
    .vmax_i      (vmax_i),
    .off_i       (tgt_off_i),
    .step_i      (step_size_i),
    .lvl_cur_i   (level_q),
    .step_cur_i  (step_q),
    .q_hi_i      (q1_q),
    .q_lo_i      (quot_now),
    .lvl_first_o (lvl_first),
    .lvl_next_o  (lvl_next),
    .slope_o     (slope)
  );

  assign rd_idx = (state_q == ST_IDLE) ? mode_i : mode_q;

  stepq_cache #(
    .IW    (MODE_W),
    .W     (QUOT_W),
    .OUT_W (SR_W)
  ) u_cache (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we_i    (cache_we),
    .widx_i  (mode_q),
    .wdata_i (slope),
    .ridx_i  (rd_idx),
    .prog_o  (step_wdata_o),
    .valid_o (cache_valid)
  );

  assign poll_active = (state_q == ST_WDONE) || (state_q == ST_WBUSY);
  assign poll_cond   = (state_q == ST_WDONE) ? done_flag_i : ~busy_flag_i;

  stepq_poll #(
    .TICKS (POLL_TICKS),
    .LIMIT (POLL_MAX)
  ) u_poll (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .active_i (poll_active),
    .cond_i   (poll_cond),
    .hit_o    (poll_hit),
    .expire_o (poll_expire)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    mode_d   = mode_q;
    step_d   = step_q;
    level_d  = level_q;
    q1_d     = q1_q;
    err_d    = err_q;
    cfg_en   = 1'b0;
    q1_en    = 1'b0;
    gap_en   = 1'b0;
    err_en   = 1'b0;
    cache_we = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cfg_en  = 1'b1;
          err_en  = 1'b1;
          mode_d  = mode_i;
          step_d  = step_size_i;
          level_d = lvl_first;
          phase_d = 1'b0;
          err_d   = 1'b0;
          state_d = cache_valid ? ST_PROG : ST_VREQ;
        end
      end
      ST_VREQ: begin
        if (vreq_ack_i) state_d = ST_WDONE;
      end
      ST_WDONE: begin
        if (poll_hit) begin
          state_d = ST_WBUSY;
        end else if (poll_expire) begin
          state_d = ST_ERR;
          err_en  = 1'b1;
          err_d   = 1'b1;
        end
      end
      ST_WBUSY: begin
        if (poll_hit) begin
          if (phase_q) begin
            cache_we = 1'b1;
            state_d  = ST_PROG;
          end else begin
            q1_en   = 1'b1;
            q1_d    = quot_now;
            state_d = ST_GAP;
          end
        end else if (poll_expire) begin
          state_d = ST_ERR;
          err_en  = 1'b1;
          err_d   = 1'b1;
        end
      end
      ST_GAP: begin
        gap_en  = 1'b1;
        phase_d = 1'b1;
        level_d = lvl_next;
        state_d = ST_VREQ;
      end
      ST_PROG: state_d = ST_IDLE;
      ST_ERR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      mode_q  <= '0;
      step_q  <= '0;
      level_q <= '0;
      q1_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cfg_en) begin
        mode_q <= mode_d;
        step_q <= step_d;
      end
      if (cfg_en || gap_en) begin
        level_q <= level_d;
        phase_q <= phase_d;
      end
      if (q1_en)  q1_q  <= q1_d;
      if (err_en) err_q <= err_d;
    end
  end

  assign vreq_valid_o = (state_q == ST_VREQ);
  assign vreq_level_o = level_q;
  assign meas_en_o    = poll_active;
  assign sw_mode_o    = (state_q == ST_VREQ) || (state_q == ST_WDONE) ||
                        (state_q == ST_WBUSY) || (state_q == ST_GAP);
  assign step_we_o    = (state_q == ST_PROG);
  assign reg_off_o    = (state_q == ST_ERR);
  assign busy_o       = (state_q != ST_IDLE);
  assign err_o        = err_q;

  // R4
  loop_off_in_vreq_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    vreq_valid_o |-> !meas_en_o);

  // R2
  vreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (vreq_valid_o && !vreq_ack_i) |=> (vreq_valid_o && $stable(vreq_level_o)));

  // R6
  step_we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    step_we_o |=> !step_we_o);

  // R8
  timeout_exit_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    reg_off_o |=> (err_o && !busy_o && !reg_off_o && !step_we_o));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    busy_o |=> $stable(mode_q));

  // R7
  skip_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (start_i && !busy_o && cache_valid) |=> (step_we_o && !vreq_valid_o));

  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (start_i && !busy_o) |=> !err_o);

endmodule

// File: tb/test_stepq_cal.sv
module test_stepq_cal;

  localparam int VOLT_W = 16;
  localparam int OFF_W  = 4;
  localparam int QUOT_W = 12;
  localparam int QLSB   = 12;
  localparam int DBG_W  = 32;
  localparam int SR_W   = 8;
  localparam int MODE_W = 2;
  localparam int PT     = 3;
  localparam int PM     = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [MODE_W-1:0] mode_i = '0;
  logic [VOLT_W-1:0] vmax_i = 16'd1200;
  logic [OFF_W-1:0]  tgt_off_i = 4'd3;
  logic [VOLT_W-1:0] step_size_i = 16'd25;
  logic              vreq_valid_o;
  logic [VOLT_W-1:0] vreq_level_o;
  logic              vreq_ack_i = 1'b0;
  logic              reg_off_o;
  logic              meas_en_o;
  logic              sw_mode_o;
  logic              done_flag_i = 1'b0;
  logic              busy_flag_i = 1'b0;
  logic [DBG_W-1:0]  meas_word_i = '0;
  logic              step_we_o;
  logic [SR_W-1:0]   step_wdata_o;
  logic              busy_o;
  logic              err_o;

  stepq_cal #(
    .VOLT_W(VOLT_W), .OFF_W(OFF_W), .QUOT_W(QUOT_W), .QLSB(QLSB),
    .DBG_W(DBG_W), .SR_W(SR_W), .MODE_W(MODE_W),
    .POLL_TICKS(PT), .POLL_MAX(PM)
  ) i_stepq_cal (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .vmax_i(vmax_i), .tgt_off_i(tgt_off_i), .step_size_i(step_size_i),
    .vreq_valid_o(vreq_valid_o), .vreq_level_o(vreq_level_o),
    .vreq_ack_i(vreq_ack_i), .reg_off_o(reg_off_o), .meas_en_o(meas_en_o),
    .sw_mode_o(sw_mode_o), .done_flag_i(done_flag_i), .busy_flag_i(busy_flag_i),
    .meas_word_i(meas_word_i), .step_we_o(step_we_o),
    .step_wdata_o(step_wdata_o), .busy_o(busy_o), .err_o(err_o)
  );

  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;

  // engine and regulator model state
  int qa = 0, qb = 0, dd = 1, bd = 1;
  int ecnt = 0;
  bit en_prev = 1'b0;
  int meas_idx = 0;
  int meas_rise = 0;
  int vreq_cnt = 0;
  int lvl_log [4];
  int we_cnt = 0;
  int we_data = 0;
  int off_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // regulator, engine and monitors, all away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (vreq_valid_o && !vreq_ack_i) begin
      if (vreq_cnt < 4) lvl_log[vreq_cnt] = int'(vreq_level_o);
      vreq_cnt++;
      vreq_ack_i = 1'b1;
    end else begin
      vreq_ack_i = 1'b0;
    end
    if (meas_en_o) begin
      if (!en_prev) begin
        ecnt = 0;
        meas_word_i = {8'hA5, (meas_idx == 0) ? 12'(qa) : 12'(qb), 12'h5C3};
        meas_idx++;
        meas_rise++;
      end else begin
        ecnt++;
      end
    end else begin
      ecnt = 0;
    end
    en_prev = meas_en_o;
    done_flag_i = meas_en_o && (ecnt >= dd);
    busy_flag_i = meas_en_o && (ecnt < dd + bd);
    if (step_we_o) begin
      we_cnt++;
      we_data = int'(step_wdata_o);
    end
    if (reg_off_o) off_cnt++;
  end

  initial begin : watchdog
    wait (cycles > 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 outputs quiet during reset
    chk(!busy_o && !err_o && !vreq_valid_o && !meas_en_o && !step_we_o && !reg_off_o,
        "R1 outputs in reset", {busy_o, err_o, vreq_valid_o, meas_en_o, step_we_o, reg_off_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !err_o && !vreq_valid_o && !meas_en_o && !sw_mode_o,
        "R1 idle after reset", {busy_o, err_o, vreq_valid_o, meas_en_o, sw_mode_o}, 0);
  endtask

  // one calibration request; extra_at > 0 pulses a second start that many cycles in
  task automatic run_cal(input int mode, input int a, input int b, input int d_dly,
                         input int b_dly, input int extra_at);
    int waited;
    qa = a; qb = b; dd = d_dly; bd = b_dly;
    meas_idx = 0; meas_rise = 0; vreq_cnt = 0; we_cnt = 0; we_data = -1; off_cnt = 0;
    mode_i = MODE_W'(mode);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R11 error cleared by the accepted start
    chk(!err_o, "R11 error cleared on start", int'(err_o), 0);
    waited = 0;
    while (busy_o && waited < 2000) begin
      waited++;
      if (extra_at != 0 && waited == extra_at) begin
        mode_i = MODE_W'(mode + 1);
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
    chk(!busy_o, "run finished", int'(busy_o), 0);
  endtask

  task automatic t_basic();
    run_cal(0, 'h800, 'h7A0, 2, 2, 0);
    chk(vreq_cnt == 2, "R2 two regulator requests", vreq_cnt, 2);
    chk(lvl_log[0] == 1125, "R2 first level", lvl_log[0], 1125);
    chk(lvl_log[1] == 1025, "R3 second level four steps lower", lvl_log[1], 1025);
    chk(meas_rise == 2, "R5 two measurements", meas_rise, 2);
    chk(we_cnt == 1 && we_data == 'h18, "R6 slope written", we_data, 'h18);
    chk(!err_o && off_cnt == 0, "R8 no error on success", off_cnt, 0);
    chk(!meas_en_o && !sw_mode_o, "R4 loop off after run", int'(meas_en_o), 0);
  endtask

  task automatic t_skip(input int mode, input int exp);
    run_cal(mode, 'h111, 'h222, 1, 1, 0);
    chk(vreq_cnt == 0, "R7 skip makes no regulator request", vreq_cnt, 0);
    chk(meas_rise == 0, "R7 skip makes no measurement", meas_rise, 0);
    chk(we_cnt == 1 && we_data == exp, "R7 cached value written", we_data, exp);
  endtask

  task automatic t_late_done();
    // done seen only at the last allowed sample
    run_cal(1, 'h47, 'h40, (PM - 1) * PT, 1, 0);
    chk(!err_o && off_cnt == 0, "R9 last sample accepted", int'(err_o), 0);
    chk(we_cnt == 1 && we_data == 1, "R6 shift drops remainder", we_data, 1);
  endtask

  task automatic t_truncate();
    run_cal(2, 'h900, 'h100, 1, 1, 0);
    chk(we_cnt == 1 && we_data == 'h00, "R6 low 8 bits of 0x200", we_data, 0);
  endtask

  task automatic t_timeout_done();
    run_cal(3, 'h100, 'h80, 100000, 1, 0);
    chk(err_o, "R8 done timeout raises error", int'(err_o), 1);
    chk(off_cnt == 1, "R8 one regulator-disable pulse", off_cnt, 1);
    chk(we_cnt == 0, "R8 no step write on timeout", we_cnt, 0);
    chk(vreq_cnt == 1, "R8 stops after first request", vreq_cnt, 1);
    chk(!meas_en_o, "R4 loop off after timeout", int'(meas_en_o), 0);
  endtask

  task automatic t_timeout_busy();
    run_cal(3, 'h100, 'h80, 1, 100000, 0);
    chk(err_o, "R8 busy timeout raises error", int'(err_o), 1);
    chk(off_cnt == 1 && we_cnt == 0, "R8 busy timeout no write", we_cnt, 0);
    chk(err_o, "R11 error held while idle", int'(err_o), 1);
  endtask

  task automatic t_clamp();
    run_cal(3, 'h100, 'h180, 1, 1, 0);
    chk(vreq_cnt == 2, "R8 mode left uncalibrated", vreq_cnt, 2);
    chk(we_cnt == 1 && we_data == 0, "R6 clamp to zero", we_data, 0);
    chk(!err_o, "R11 error cleared after success", int'(err_o), 0);
  endtask

  task automatic t_restart_ignored();
    do_reset();
    vmax_i = 16'd1000; tgt_off_i = 4'd0; step_size_i = 16'd10;
    run_cal(0, 'h300, 'h200, 2, 1, 5);
    chk(vreq_cnt == 2, "R10 second start ignored", vreq_cnt, 2);
    chk(meas_rise == 2, "R10 no extra measurement", meas_rise, 2);
    chk(lvl_log[0] == 1000 && lvl_log[1] == 960, "R3 levels with zero offset", lvl_log[1], 960);
    chk(we_cnt == 1 && we_data == 'h40, "R10 original mode result", we_data, 'h40);
    run_cal(1, 'h300, 'h200, 1, 1, 0);
    chk(vreq_cnt == 2, "R1 reset cleared cache, R10 mode 1 untouched", vreq_cnt, 2);
  endtask

  initial begin
    do_reset();
    t_basic();
    t_skip(0, 'h18);
    t_late_done();
    t_truncate();
    t_skip(2, 'h00);
    t_timeout_done();
    t_timeout_busy();
    t_clamp();
    t_skip(3, 'h00);
    t_skip(1, 'h01);
    t_restart_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule